// File: doc/BRIEF.md
# Multichannel Serializing Output FIFO

This block moves wide parallel data from a core-logic clock domain into an I/O-side clock domain. It has ten byte-wide channels that share one storage array. The array is eight entries deep, and each entry holds one byte for every channel. One write pointer and one read pointer serve all ten lanes. The two pointers cross between the clock domains as Gray codes, each through a two-flop synchronizer. Full is computed on the write side and empty on the read side.

A parameter selects one of two drain styles. In same-rate mode each read returns one nibble per narrow channel and consumes one entry. In split mode each stored byte leaves as two nibbles on two successive reads, low nibble first, so one entry is consumed every second read. Channels 5 and 6 are wide: they present the whole stored byte on every read and hold it steady across both halves. A second parameter forces every output byte to zero while the flags and handshakes keep working.

Both sides use valid/ready handshakes, and a transfer happens only on a cycle where both are high. On the write side `in_ready` is low whenever the FIFO is full, and a write offered then is dropped, not queued. On the read side `out_valid` is low whenever the FIFO is empty. The output data is shown combinationally from the head entry, so a consumer can look at it before it accepts. A reset input clears both sides to empty at any time.

Top module: `ser_out_fifo`

## Requirements
- R1: Asserting `rst` clears the FIFO to empty: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `in_ready`=1, `out_valid`=0.
- R2: A write happens on a `wr_clk` edge where `in_valid` and `in_ready` are both high. It stores the ten bytes of `in_data`, with channel c in bits [8c+7:8c]. Eight stored entries make `full`=1 and `in_ready`=0.
- R3: With SPLIT_MODE=1, the first read of an entry puts the low nibble of each narrow channel's byte in bits [3:0] of that channel's output slot. The second read puts the high nibble there. The entry is released only after the second read.
- R4: With SPLIT_MODE=0, every read shows the low nibble of each narrow channel's byte in bits [3:0] of its slot and releases one entry.
- R5: Channels 5 and 6 show the whole stored byte in their 8-bit output slot on every read, in both modes. In split mode the byte stays the same across both halves of an entry.
- R6: Bits [7:4] of every narrow channel's output slot are always zero.
- R7: `almost_full` is high while the number of free slots is at most AF_THRESH (1 or 2), which includes the full state.
- R8: `almost_empty` is high while the number of stored entries is at most AE_THRESH (1 or 2), which includes the empty state.
- R9: A write offered while full and a read requested while empty have no effect. The stored data and its order are unchanged.
- R10: With OUT_OFF=1, `out_data` is all zeros, while the flags and handshakes behave as in R1 to R8.
- R11: Entries leave in the order they were written, including after the pointers wrap around the eight-entry array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high asynchronous reset for both sides |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | High when a write can be accepted (not full) |
| in_data | input | 80 | Ten input bytes, channel c at [8c+7:8c] |
| out_valid | output | 1 | High when the head entry can be read (not empty) |
| out_ready | input | 1 | Read request; one read per cycle with `out_valid` |
| out_data | output | 80 | Ten output slots, channel c at [8c+7:8c] |
| empty | output | 1 | No entry stored (read-clock domain) |
| almost_empty | output | 1 | Stored entries at most AE_THRESH |
| full | output | 1 | All eight entries used (write-clock domain) |
| almost_full | output | 1 | Free slots at most AF_THRESH |

## Verification
The assertions check on every cycle that a full FIFO never moves its write pointer and an empty FIFO never moves its read pointer. They also check that the read pointer moves only on an accepted read, that each of full and empty implies its "almost" flag, and that in split mode the first half of a read never releases the entry. Only the bench scenarios can show the actual nibble order, the wide-lane bytes, the zeroed outputs, the threshold crossings and the data order after wrap. They do this by comparing `out_data` against bytes the bench wrote earlier.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;
  localparam int GW = 16;

  function automatic logic [GW-1:0] bin_to_gray(logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray_to_bin(logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/ofifo_sync.sv
module ofifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ofifo_wr_ctrl.sv
module ofifo_wr_ctrl #(
  parameter int DEPTH     = 8,
  parameter int PTR_W     = 4,
  parameter int AF_THRESH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic [PTR_W-1:0] rd_gray_s,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] wr_gray,
  output logic             full,
  output logic             almost_full,
  output logic             wr_fire
);
  logic [PTR_W-1:0] rd_bin_s;
  logic [PTR_W-1:0] used;
  logic [PTR_W-1:0] free_slots;
  logic [PTR_W-1:0] wr_next;

  assign rd_bin_s    = PTR_W'(ofifo_pkg::gray_to_bin(16'(rd_gray_s)));
  assign used        = wr_ptr - rd_bin_s;
  assign free_slots  = PTR_W'(DEPTH) - used;
  assign full        = (used == PTR_W'(DEPTH));
  assign almost_full = (free_slots <= PTR_W'(AF_THRESH));
  assign wr_fire     = push_req & ~full;
  assign wr_next     = wr_ptr + 1'b1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_ptr  <= '0;
      wr_gray <= '0;
    end else if (wr_fire) begin
      wr_ptr  <= wr_next;
      wr_gray <= PTR_W'(ofifo_pkg::bin_to_gray(16'(wr_next)));
    end
  end
endmodule

// File: rtl/ofifo_rd_ctrl.sv
module ofifo_rd_ctrl #(
  parameter int DEPTH      = 8,
  parameter int PTR_W      = 4,
  parameter int AE_THRESH  = 1,
  parameter int SPLIT_MODE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_req,
  input  logic [PTR_W-1:0] wr_gray_s,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] rd_gray,
  output logic             rd_half,
  output logic             empty,
  output logic             almost_empty
);
  logic [PTR_W-1:0] wr_bin_s;
  logic [PTR_W-1:0] stored;
  logic [PTR_W-1:0] rd_next;
  logic             pop_fire;
  logic             advance;

  assign wr_bin_s     = PTR_W'(ofifo_pkg::gray_to_bin(16'(wr_gray_s)));
  assign stored       = wr_bin_s - rd_ptr;
  assign empty        = (wr_gray_s == rd_gray);
  assign almost_empty = (stored <= PTR_W'(AE_THRESH));
  assign pop_fire     = pop_req & ~empty;
  assign rd_next      = rd_ptr + 1'b1;

  generate
    if (SPLIT_MODE != 0) begin : g_split
      always_ff @(posedge clk or posedge rst) begin
        if (rst)           rd_half <= 1'b0;
        else if (pop_fire) rd_half <= ~rd_half;
      end
      assign advance = pop_fire & rd_half;
    end else begin : g_same
      assign rd_half = 1'b0;
      assign advance = pop_fire;
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rd_ptr  <= '0;
      rd_gray <= '0;
    end else if (advance) begin
      rd_ptr  <= rd_next;
      rd_gray <= PTR_W'(ofifo_pkg::bin_to_gray(16'(rd_next)));
    end
  end
endmodule

// File: rtl/ser_out_fifo.sv
module ser_out_fifo #(
  parameter int              NUM_CH     = 10,
  parameter int              IN_W       = 8,
  parameter int              DEPTH      = 8,
  parameter int              SPLIT_MODE = 1,
  parameter int              AE_THRESH  = 1,
  parameter int              AF_THRESH  = 1,
  parameter int              OUT_OFF    = 0,
  parameter logic [NUM_CH-1:0] WIDE_MASK = NUM_CH'(10'h060)
) (
  input  logic                   wr_clk,
  input  logic                   rd_clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NUM_CH*IN_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NUM_CH*IN_W-1:0] out_data,
  output logic                   empty,
  output logic                   almost_empty,
  output logic                   full,
  output logic                   almost_full
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int HALF_W = IN_W / 2;
  localparam int ROW_W  = NUM_CH * IN_W;

  logic [ROW_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0] head;
  logic [ROW_W-1:0] lanes;

  logic [PTR_W-1:0] wr_ptr, wr_gray, wr_gray_s;
  logic [PTR_W-1:0] rd_ptr, rd_gray, rd_gray_s;
  logic             wr_fire;
  logic             rd_half;

  ofifo_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .AF_THRESH(AF_THRESH)) u_wr (
    .clk(wr_clk), .rst(rst), .push_req(in_valid), .rd_gray_s(rd_gray_s),
    .wr_ptr(wr_ptr), .wr_gray(wr_gray), .full(full),
    .almost_full(almost_full), .wr_fire(wr_fire)
  );

  ofifo_rd_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .AE_THRESH(AE_THRESH),
                  .SPLIT_MODE(SPLIT_MODE)) u_rd (
    .clk(rd_clk), .rst(rst), .pop_req(out_ready), .wr_gray_s(wr_gray_s),
    .rd_ptr(rd_ptr), .rd_gray(rd_gray), .rd_half(rd_half),
    .empty(empty), .almost_empty(almost_empty)
  );

  ofifo_sync #(.W(PTR_W)) u_sync_w2r (.clk(rd_clk), .rst(rst), .d(wr_gray), .q(wr_gray_s));
  ofifo_sync #(.W(PTR_W)) u_sync_r2w (.clk(wr_clk), .rst(rst), .d(rd_gray), .q(rd_gray_s));

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[wr_ptr[ADDR_W-1:0]] <= in_data;
  end

  assign head = mem[rd_ptr[ADDR_W-1:0]];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      if (WIDE_MASK[c]) begin : g_wide
        assign lanes[c*IN_W +: IN_W] = head[c*IN_W +: IN_W];
      end else begin : g_narrow
        assign lanes[c*IN_W +: IN_W] = {{(IN_W-HALF_W){1'b0}},
          (rd_half ? head[c*IN_W+HALF_W +: HALF_W] : head[c*IN_W +: HALF_W])};
      end
    end
  endgenerate

  assign out_data  = (OUT_OFF != 0) ? '0 : lanes;
  assign in_ready  = ~full;
  assign out_valid = ~empty;
endmodule

// File: rtl/ofifo_checker.sv
module ofifo_checker #(
  parameter int PTR_W = 4,
  parameter int SPLIT = 1
) (
  input logic             wclk,
  input logic             rclk,
  input logic             rst,
  input logic             full,
  input logic             almost_full,
  input logic             empty,
  input logic             almost_empty,
  input logic             out_valid,
  input logic             out_ready,
  input logic             half,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr
);
  AST_FULL_FREEZES_WPTR: assert property (@(posedge wclk) disable iff (rst)
    full |=> $stable(wr_ptr)); // R9
  AST_EMPTY_FREEZES_RPTR: assert property (@(posedge rclk) disable iff (rst)
    empty |=> $stable(rd_ptr)); // R9
  AST_FULL_HAS_AF: assert property (@(posedge wclk) disable iff (rst)
    full |-> almost_full); // R7
  AST_EMPTY_HAS_AE: assert property (@(posedge rclk) disable iff (rst)
    empty |-> almost_empty); // R8
  AST_FIRST_HALF_KEEPS: assert property (@(posedge rclk) disable iff (rst)
    (SPLIT != 0 && out_valid && out_ready && !half) |=> !empty); // R3
  AST_RPTR_ONLY_ON_READ: assert property (@(posedge rclk) disable iff (rst)
    !(out_valid && out_ready) |=> $stable(rd_ptr)); // R11
endmodule

bind ser_out_fifo ofifo_checker #(.PTR_W(PTR_W), .SPLIT(SPLIT_MODE)) u_chk (
  .wclk(wr_clk), .rclk(rd_clk), .rst(rst), .full(full),
  .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty),
  .out_valid(out_valid), .out_ready(out_ready), .half(rd_half),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/test_ser_out_fifo.sv
module test_ser_out_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int W          = 80;

  logic wr_clk = 0, rd_clk = 0, rst = 1;
  logic in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic [2:0] ordy = '0;
  logic [2:0] ovalid, iready, empty_v, ae_v, full_v, af_v;
  logic [W-1:0] odata [3];
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  // instance 0: split mode, 1: same-rate mode, 2: split mode with outputs off
  ser_out_fifo #(.SPLIT_MODE(1)) i_ser_out_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .in_valid(in_valid),
    .in_ready(iready[0]), .in_data(in_data), .out_valid(ovalid[0]),
    .out_ready(ordy[0]), .out_data(odata[0]), .empty(empty_v[0]),
    .almost_empty(ae_v[0]), .full(full_v[0]), .almost_full(af_v[0]));
  ser_out_fifo #(.SPLIT_MODE(0)) i_ser_out_fifo_flat (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .in_valid(in_valid),
    .in_ready(iready[1]), .in_data(in_data), .out_valid(ovalid[1]),
    .out_ready(ordy[1]), .out_data(odata[1]), .empty(empty_v[1]),
    .almost_empty(ae_v[1]), .full(full_v[1]), .almost_full(af_v[1]));
  ser_out_fifo #(.SPLIT_MODE(1), .OUT_OFF(1)) i_ser_out_fifo_off (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .in_valid(in_valid),
    .in_ready(iready[2]), .in_data(in_data), .out_valid(ovalid[2]),
    .out_ready(ordy[2]), .out_data(odata[2]), .empty(empty_v[2]),
    .almost_empty(ae_v[2]), .full(full_v[2]), .almost_full(af_v[2]));

  function automatic logic [7:0] pat(int k, int c);
    return 8'((k * 37 + c * 29 + 3) & 255);
  endfunction

  function automatic logic [W-1:0] row(int k);
    logic [W-1:0] v;
    for (int c = 0; c < 10; c++) v[c*8 +: 8] = pat(k, c);
    return v;
  endfunction

  function automatic logic [W-1:0] expect_out(int inst, int k, bit hi);
    logic [W-1:0] v;
    logic [7:0] b;
    if (inst == 2) return '0;
    for (int c = 0; c < 10; c++) begin
      b = pat(k, c);
      if (c == 5 || c == 6) v[c*8 +: 8] = b;
      else v[c*8 +: 8] = {4'h0, (hi && inst == 0) ? b[7:4] : b[3:0]};
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(int inst, bit e, bit ae, bit f, bit af, string req);
    logic [W-1:0] act, exp;
    act = W'({empty_v[inst], ae_v[inst], full_v[inst], af_v[inst], iready[inst], ovalid[inst]});
    exp = W'({e, ae, f, af, ~f, ~e});
    check(act == exp, req, $sformatf("flags inst%0d {e,ae,f,af,irdy,ovld}", inst), act, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic write_entry(int k);
    @(negedge wr_clk);
    in_valid = 1;
    in_data  = row(k);
    @(negedge wr_clk);
    in_valid = 0;
  endtask

  task automatic read_one(int inst, int k, bit hi, string req);
    logic [W-1:0] exp;
    @(negedge rd_clk);
    exp = expect_out(inst, k, hi);
    check(ovalid[inst] == 1'b1, req, $sformatf("out_valid inst%0d", inst), W'(ovalid[inst]), W'(1));
    check(odata[inst] == exp, req, $sformatf("data inst%0d entry%0d half%0d", inst, k, hi),
          odata[inst], exp);
    ordy[inst] = 1;
    @(negedge rd_clk);
    ordy[inst] = 0;
  endtask

  task automatic drain_all(int k0, int n, string req);
    for (int k = k0; k < k0 + n; k++) begin
      read_one(0, k, 0, req); read_one(0, k, 1, req);
      read_one(1, k, 0, req);
      read_one(2, k, 0, req); read_one(2, k, 1, req);
    end
    settle();
    for (int i = 0; i < 3; i++) check_flags(i, 1, 1, 0, 0, req);
  endtask

  task automatic t_reset();
    rst = 1; ordy = '0; in_valid = 0;
    repeat (3) @(negedge wr_clk);
    rst = 0;
    settle();
    for (int i = 0; i < 3; i++) check_flags(i, 1, 1, 0, 0, "R1");
  endtask

  // R2 R7 R9 R3 R4 R5 R6 R10: fill to full, offer an extra write, drain each
  task automatic t_fill_drain();
    for (int k = 0; k < 8; k++) begin
      write_entry(k);
      if (k == 5) check(af_v[0] == 0, "R7", "af at 2 free", W'(af_v[0]), W'(0));
      if (k == 6) begin
        check(af_v[0] == 1, "R7", "af at 1 free", W'(af_v[0]), W'(1));
        check(full_v[0] == 0, "R2", "not full at 7", W'(full_v[0]), W'(0));
      end
    end
    for (int i = 0; i < 3; i++) check_flags(i, 0, 0, 1, 1, "R2");
    write_entry(99);
    check(full_v[0] == 1, "R9", "still full after extra write", W'(full_v[0]), W'(1));
    settle();
    for (int i = 0; i < 3; i++) check_flags(i, 0, 0, 1, 1, "R8");
    drain_all(0, 8, "R3 R4 R5 R6 R9 R10");
  endtask

  task automatic t_almost_empty();
    write_entry(20); write_entry(21);
    settle();
    for (int i = 0; i < 3; i++) check(ae_v[i] == 0, "R8", "ae with 2 stored", W'(ae_v[i]), W'(0));
    read_one(0, 20, 0, "R3");
    @(negedge rd_clk);
    check(ae_v[0] == 0, "R8", "ae after first half", W'(ae_v[0]), W'(0));
    read_one(0, 20, 1, "R3");
    read_one(1, 20, 0, "R4");
    read_one(2, 20, 0, "R10"); read_one(2, 20, 1, "R10");
    @(negedge rd_clk);
    for (int i = 0; i < 3; i++) check_flags(i, 0, 1, 0, 0, "R8");
    read_one(0, 21, 0, "R3"); read_one(0, 21, 1, "R3");
    read_one(1, 21, 0, "R4");
    read_one(2, 21, 0, "R10"); read_one(2, 21, 1, "R10");
    settle();
    for (int i = 0; i < 3; i++) check_flags(i, 1, 1, 0, 0, "R8");
  endtask

  task automatic t_read_empty();
    @(negedge rd_clk);
    ordy = 3'b111;
    repeat (3) @(negedge rd_clk);
    ordy = '0;
    for (int i = 0; i < 3; i++) check_flags(i, 1, 1, 0, 0, "R9");
    write_entry(30);
    settle();
    drain_all(30, 1, "R9");
  endtask

  task automatic t_wrap();
    for (int k = 50; k < 55; k++) write_entry(k);
    settle();
    drain_all(50, 5, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_drain();
    t_almost_empty();
    t_read_empty();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule